// File: doc/BRIEF.md
# Dual-Mode Transition Controller

This block decides which of two serial protocols owns a shared data line. Out of reset it selects the streaming mode, in which a serializer shifts stored bytes out on a dedicated stream clock. When the bidirectional bus clock falls, the controller enters an intermediate waiting mode. It then counts rising edges of the stream clock and watches for a control-byte match reported by the bus slave. A match locks the controller into bidirectional bus mode until reset. If the count reaches the fallback limit while the bus clock is idle, it returns to streaming mode and gives the serializer a single-cycle restart pulse.

Both clock inputs must already be synchronized to the system clock. Edges are detected against a registered copy of each input. The mode flags are registered and one-hot. In bus mode the write qualifier is the stream clock level gated by the bus-mode flag. The limit (default 128) and the counter width (default 8) are parameters.

Top module: `dual_mode_ctrl`

## Requirements
- R1: In the cycle after synchronous reset, the streaming flag is 1, the waiting and bus flags are 0, restart is 0, and the write qualifier is 0.
- R2: A falling edge of the bus clock (1 in the previous cycle, 0 now) in streaming mode sets the waiting flag in the next cycle.
- R3: In waiting mode, each rising stream-clock edge adds one to a pulse count. After 127 edges the controller stays in waiting mode. With 128 edges and the bus clock at 1, it moves to streaming mode on the next clock.
- R4: In waiting mode, a bus-clock falling edge clears the pulse count. The full limit is then needed again before any fallback.
- R5: The restart output goes high for exactly one cycle, at the same time as the streaming flag returns from waiting mode. It is 0 at all other times.
- R6: A control-byte match in waiting mode sets the bus flag in the next cycle. If a match and the fallback condition occur in the same cycle, the match wins and no restart is given.
- R7: Once in bus mode, the controller stays there until reset. Stream-clock pulses, bus-clock edges and further matches have no effect.
- R8: The write qualifier is 1 only when the bus flag is 1 and the stream clock input is high.
- R9: If the count reaches the limit while the bus clock is held low, the controller stays in waiting mode. The count saturates rather than wrapping. Fallback happens on the first cycle with the bus clock at 1.
- R10: A control-byte match in streaming mode has no effect.
- R11: Exactly one mode flag is set in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strm_clk | input | 1 | Synchronized stream clock |
| bus_clk | input | 1 | Synchronized bidirectional bus clock |
| ctl_match | input | 1 | Control-byte match pulse from the bus slave |
| mode_stream | output | 1 | Streaming mode flag |
| mode_wait | output | 1 | Waiting (transition) mode flag |
| mode_bus | output | 1 | Bidirectional bus mode flag |
| restart | output | 1 | One-cycle serializer restart on fallback |
| wr_allow | output | 1 | Write qualifier in bus mode |

## Verification
The waiting window is tested with several stream-pulse patterns.
- Exactly 127 pulses and exactly 128 pulses show whether the limit is off by one.
- A bus-clock fall after 100 pulses shows whether the count is really cleared, or only paused.
- Holding the bus clock low through 300 pulses separates a saturating count from a wrapping one. It also shows whether idle is required before fallback.
- A match that arrives on the same cycle as the fallback condition settles the priority between the two.
- Long pulse trains and bus-clock edges after the lock confirm that bus mode is permanent.

// File: rtl/dual_mode_pkg.sv
package dual_mode_pkg;

    typedef enum logic [1:0] {
        MD_STREAM = 2'd0,
        MD_WAIT   = 2'd1,
        MD_BUS    = 2'd2
    } mode_e;

    typedef struct packed {
        logic bus;
        logic wait_st;
        logic stream;
    } mode_flags_t;

    function automatic mode_flags_t flags_of(mode_e m);
        mode_flags_t f;
        f = '0;
        case (m)
            MD_WAIT: f.wait_st = 1'b1;
            MD_BUS:  f.bus     = 1'b1;
            default: f.stream  = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/mode_edge_det.sv
module mode_edge_det #(
    parameter bit DETECT_RISE = 1'b1,
    parameter bit IDLE_LVL    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic edge_p
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LVL;
        else     prev_q <= sig;
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_p = sig & ~prev_q;
        end else begin : g_fall
            assign edge_p = ~sig & prev_q;
        end
    endgenerate
endmodule

// File: rtl/mode_pulse_cnt.sv
module mode_pulse_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr || !en)               cnt <= '0;
        else if (inc && (cnt != CNT_MAX))    cnt <= cnt + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R4
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R9
endmodule

// File: rtl/dual_mode_ctrl.sv
module dual_mode_ctrl #(
    parameter int CNT_W        = 8,
    parameter int FALLBACK_CNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic strm_clk,
    input  logic bus_clk,
    input  logic ctl_match,
    output logic mode_stream,
    output logic mode_wait,
    output logic mode_bus,
    output logic restart,
    output logic wr_allow
);
    import dual_mode_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FALLBACK_CNT);

    logic             strm_rise;
    logic             bus_fall;
    logic [CNT_W-1:0] pulse_cnt;
    mode_e            state_q, state_d;
    mode_flags_t      flags_q;
    logic             restart_q, restart_d;

    mode_edge_det #(.DETECT_RISE(1'b1), .IDLE_LVL(1'b1)) u_strm_edge (
        .clk(clk), .rst(rst), .sig(strm_clk), .edge_p(strm_rise)
    );

    mode_edge_det #(.DETECT_RISE(1'b0), .IDLE_LVL(1'b1)) u_bus_edge (
        .clk(clk), .rst(rst), .sig(bus_clk), .edge_p(bus_fall)
    );

    mode_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .en (state_q == MD_WAIT),
        .inc(strm_rise),
        .clr(bus_fall),
        .cnt(pulse_cnt)
    );

    always_comb begin
        state_d   = state_q;
        restart_d = 1'b0;
        case (state_q)
            MD_STREAM: if (bus_fall) state_d = MD_WAIT;
            MD_WAIT: begin
                if (ctl_match) begin
                    state_d = MD_BUS;
                end else if (!bus_fall && bus_clk && (pulse_cnt >= LIMIT)) begin
                    state_d   = MD_STREAM;
                    restart_d = 1'b1;
                end
            end
            default: state_d = MD_BUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= MD_STREAM;
            flags_q   <= flags_of(MD_STREAM);
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            flags_q   <= flags_of(state_d);
            restart_q <= restart_d;
        end
    end

    assign mode_stream = flags_q.stream;
    assign mode_wait   = flags_q.wait_st;
    assign mode_bus    = flags_q.bus;
    assign restart     = restart_q;
    assign wr_allow    = flags_q.bus & strm_clk;

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot({mode_bus, mode_wait, mode_stream})); // R11
    AST_ENTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mode_stream && bus_fall) |=> mode_wait); // R2
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart); // R5
    AST_RESTART_IN_STREAM: assert property (@(posedge clk) disable iff (rst)
        restart |-> (mode_stream && $past(mode_wait))); // R5
    AST_BUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode_bus |=> mode_bus); // R7
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode_wait && ctl_match) |=> (mode_bus && !restart)); // R6
endmodule

// File: tb/sim_dual_mode_ctrl.sv
module sim_dual_mode_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strm_clk = 1'b0;
    logic bus_clk = 1'b1;
    logic ctl_match = 1'b0;
    logic mode_stream, mode_wait, mode_bus, restart, wr_allow;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_mode_ctrl u0 (
        .clk(clk), .rst(rst), .strm_clk(strm_clk), .bus_clk(bus_clk),
        .ctl_match(ctl_match), .mode_stream(mode_stream), .mode_wait(mode_wait),
        .mode_bus(mode_bus), .restart(restart), .wr_allow(wr_allow)
    );

    // vector: {bus_clk, strm_clk, ctl_match, exp_bus, exp_wait, exp_stream, exp_restart, exp_wr}
    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{
        8'b100_001_0_0,
        8'b111_001_0_0,  // R10 match in streaming ignored
        8'b100_001_0_0,
        8'b000_010_0_0,  // R2 fall enters waiting
        8'b100_010_0_0,
        8'b110_010_0_0,
        8'b101_100_0_0,  // R6 match locks bus mode
        8'b000_100_0_0,  // R7 fall ignored
        8'b110_100_0_1   // R8 write allowed with strm high
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] modes();
        return {mode_bus, mode_wait, mode_stream};
    endfunction

    task automatic do_reset();
        rst = 1'b1; bus_clk = 1'b1; strm_clk = 1'b0; ctl_match = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic bus_fall_rise();
        bus_clk = 1'b0; step();
        bus_clk = 1'b1; step();
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            strm_clk = 1'b1; step();
            strm_clk = 1'b0; step();
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        step();
        strm_clk = 1'b1;
        #0.1;
        check("R1 modes", modes(), 3'b001);
        check("R1 restart", restart, 0);
        check("R1 wr_allow", wr_allow, 0);
        strm_clk = 1'b0;

        for (int v = 0; v < NV; v++) begin
            bus_clk = VEC[v][7]; strm_clk = VEC[v][6]; ctl_match = VEC[v][5];
            step();
            check($sformatf("vector %0d modes", v), modes(), VEC[v][4:2]);
            check($sformatf("vector %0d restart", v), restart, VEC[v][1]);
            check($sformatf("vector %0d wr_allow", v), wr_allow, VEC[v][0]);
        end
        ctl_match = 1'b0;

        // R3 / R5: 127 edges hold, 128th triggers fallback
        do_reset();
        bus_fall_rise();
        check("R2 waiting", modes(), 3'b010);
        pulses(127);
        check("R3 127 pulses still waiting", modes(), 3'b010);
        strm_clk = 1'b1; step();
        check("R3 128th edge state not yet moved", modes(), 3'b010);
        strm_clk = 1'b0; step();
        check("R3 fallback to streaming", modes(), 3'b001);
        check("R5 restart high", restart, 1);
        step();
        check("R5 restart single cycle", restart, 0);
        check("R11 streaming stays", modes(), 3'b001);

        // R4: bus fall clears count
        do_reset();
        bus_fall_rise();
        pulses(100);
        bus_fall_rise();
        pulses(100);
        check("R4 cleared count still waiting", modes(), 3'b010);
        check("R5 no restart while waiting", restart, 0);
        pulses(27);
        check("R4 127 after clear still waiting", modes(), 3'b010);
        pulses(1);
        check("R4 fallback after full limit", modes(), 3'b001);
        check("R4 restart", restart, 1);

        // R6: match and fallback in same cycle
        do_reset();
        bus_fall_rise();
        pulses(127);
        strm_clk = 1'b1; step();
        strm_clk = 1'b0; ctl_match = 1'b1; step();
        ctl_match = 1'b0;
        check("R6 match wins over fallback", modes(), 3'b100);
        check("R6 no restart", restart, 0);

        // R7 / R8: bus mode is permanent
        pulses(300);
        bus_fall_rise();
        ctl_match = 1'b1; step(); ctl_match = 1'b0;
        check("R7 bus mode sticky", modes(), 3'b100);
        check("R7 no restart", restart, 0);
        strm_clk = 1'b1; step();
        check("R8 wr_allow high", wr_allow, 1);
        strm_clk = 1'b0; step();
        check("R8 wr_allow low", wr_allow, 0);

        // R9: count saturates while bus held low
        do_reset();
        bus_clk = 1'b0; step();
        check("R9 entered waiting", modes(), 3'b010);
        pulses(300);
        check("R9 no fallback while bus low", modes(), 3'b010);
        check("R9 no restart while bus low", restart, 0);
        bus_clk = 1'b1; step();
        check("R9 fallback on bus idle", modes(), 3'b001);
        check("R9 restart", restart, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule